// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Selectable Synchronizer Depth

This block carries data words from a producer clock domain to a consumer clock domain when the two clocks are unrelated. The producer supplies its own clock together with the write data and a write enable. The consumer reads with its own clock, and the oldest stored word is always visible on the read data port, so it can be used directly as an operand. A read enable pops that word. Either clock may stop at any time, restart later, or change frequency. These events change only latency and throughput. They never change the data.

Each side keeps a binary pointer that is one bit wider than the address, plus a Gray-coded copy of it. Only the Gray copy crosses to the other domain. On arrival it passes through a chain of synchronizer flops whose length is selected at run time: two stages, or three stages for more metastability margin. Each side compares its own pointer with the synchronized pointer from the other side. From this the write side raises a stall when the FIFO is full, and the read side raises a stall when it is empty. A refused access leaves the stored data untouched. The words are held in an internal register array. When both clocks run at the same rate, the FIFO moves one word per cycle.

Top module: `dcf_fifo`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `rd_stall_o` is 1 and `wr_stall_o` is 0.
- R2: With equal clock rates and any pattern of write and read enables, the words come out in write order with their values unchanged.
- R3: With unrelated clock rates (up to 3.5:1 in either direction), the words still come out in order and unchanged. Each Gray pointer register changes by at most one bit per clock of its own domain.
- R4: While the read side does not consume, `wr_stall_o` rises after exactly DEPTH (16) accepted words. Writes attempted while the write side is stalled are dropped and never show up at the read side.
- R5: A read attempted while `rd_stall_o` is 1 pops nothing. The read pointer never passes the synchronized write pointer.
- R6: `sync_sel_i` = 0 selects two synchronizer stages and `sync_sel_i` = 1 selects three. Going from 0 to 1 adds exactly one read-clock cycle to the write-to-visible latency of a word written into an empty FIFO.
- R7: When both clocks have the same period and both sides request every cycle, one word is transferred per cycle. After the first word arrives, neither side sees a stall.
- R8: Stopping either clock for any length of time, at any point, loses, duplicates and reorders no word.
- R9: Whenever `rd_stall_o` is 0, `rd_data_o` shows the oldest unread word. The value stays constant while `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Producer clock |
| rclk_i | input | 1 | Consumer clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| sync_sel_i | input | SEL_W (1) | Synchronizer depth: 0 selects two stages, 1 selects three |
| wr_en_i | input | 1 | Write request (producer domain) |
| wr_data_i | input | DATA_W (16) | Write word |
| wr_stall_o | output | 1 | FIFO full; a write in this cycle is refused |
| rd_en_i | input | 1 | Pop request (consumer domain) |
| rd_data_o | output | DATA_W (16) | Oldest unread word |
| rd_stall_o | output | 1 | FIFO empty; a pop in this cycle is refused |

## Verification
The assertions check every cycle that:
- each Gray pointer moves by at most one bit;
- the pointer distance seen from either side stays between zero and DEPTH;
- a stall persists until the other side's synchronized pointer moves;
- the head word holds steady while it is not popped.

Only the bench scenarios can show the following:
- end-to-end ordering and data integrity across clock ratios and halts;
- the exact fill count at which the write stall rises;
- the one-cycle latency step between the two synchronizer settings;
- zero stalls at full rate with matched clocks.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int SYNC_MIN_STG = 2;
  localparam int SYNC_MAX_STG = 3;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W       = 5,
  parameter int MIN_STG = 2,
  parameter int MAX_STG = 3,
  parameter int SEL_W   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stg_q [MAX_STG];

  for (genvar g = 0; g < MAX_STG; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  // tap selection; out-of-range settings clamp to the deepest stage
  always_comb begin
    int tap;
    tap = MIN_STG - 1 + int'(sel_i);
    if (tap > MAX_STG - 1) tap = MAX_STG - 1;
    q_o = stg_q[MAX_STG-1];
    for (int k = 0; k < MAX_STG; k++)
      if (k == tap) q_o = stg_q[k];
  end

  p_sel_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sel_i) <= MAX_STG - MIN_STG);
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl import dcf_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int SYNC_MIN = 2,
  parameter int SYNC_MAX = 3,
  parameter int SEL_W    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sync_sel_i,
  input  logic             wr_en_i,
  input  logic [ADDR_W:0]  rgray_i,
  output logic [ADDR_W:0]  wgray_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic             take_o,
  output logic             full_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin_q, wgray_q, wbin_d, rsync;

  dcf_gray_sync #(.W(PW), .MIN_STG(SYNC_MIN), .MAX_STG(SYNC_MAX), .SEL_W(SEL_W)) u_rsync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sync_sel_i),
    .d_i   (rgray_i),
    .q_o   (rsync)
  );

  // full: same address, opposite wrap; in Gray the top two bits invert
  assign full_o  = (wgray_q == {~rsync[PW-1:PW-2], rsync[PW-3:0]});
  assign take_o  = wr_en_i & ~full_o;
  assign wbin_d  = wbin_q + PW'(take_o);
  assign wgray_o = wgray_q;
  assign waddr_o = wbin_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= PW'(bin2gray(32'(wbin_d)));
    end
  end

  logic [PW-1:0] rq_bin, occ;
  assign rq_bin = PW'(gray2bin(32'(rsync)));
  assign occ    = wbin_q - rq_bin;

  p_wgray_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PW'(DEPTH));
  p_full_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> (full_o || !$stable(rsync)));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl import dcf_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int SYNC_MIN = 2,
  parameter int SYNC_MAX = 3,
  parameter int SEL_W    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sync_sel_i,
  input  logic             rd_en_i,
  input  logic [ADDR_W:0]  wgray_i,
  output logic [ADDR_W:0]  rgray_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic             empty_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] rbin_q, rgray_q, rbin_d, wsync;
  logic          take;

  dcf_gray_sync #(.W(PW), .MIN_STG(SYNC_MIN), .MAX_STG(SYNC_MAX), .SEL_W(SEL_W)) u_wsync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sync_sel_i),
    .d_i   (wgray_i),
    .q_o   (wsync)
  );

  assign empty_o = (rgray_q == wsync);
  assign take    = rd_en_i & ~empty_o;
  assign rbin_d  = rbin_q + PW'(take);
  assign rgray_o = rgray_q;
  assign raddr_o = rbin_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= PW'(bin2gray(32'(rbin_d)));
    end
  end

  logic [PW-1:0] wq_bin, avail;
  assign wq_bin = PW'(gray2bin(32'(wsync)));
  assign avail  = wq_bin - rbin_q;

  p_rgray_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail <= PW'(DEPTH));
  p_empty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> (empty_o || !$stable(wsync)));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo import dcf_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int SYNC_MIN = SYNC_MIN_STG,
  parameter int SYNC_MAX = SYNC_MAX_STG,
  parameter int SEL_W    = (SYNC_MAX > SYNC_MIN) ? $clog2(SYNC_MAX - SYNC_MIN + 1) : 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sync_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_stall_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_stall_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wgray, rgray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_take;

  dcf_wr_ctl #(.ADDR_W(ADDR_W), .SYNC_MIN(SYNC_MIN), .SYNC_MAX(SYNC_MAX), .SEL_W(SEL_W)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .sync_sel_i(sync_sel_i),
    .wr_en_i   (wr_en_i),
    .rgray_i   (rgray),
    .wgray_o   (wgray),
    .waddr_o   (waddr),
    .take_o    (wr_take),
    .full_o    (wr_stall_o)
  );

  dcf_rd_ctl #(.ADDR_W(ADDR_W), .SYNC_MIN(SYNC_MIN), .SYNC_MAX(SYNC_MAX), .SEL_W(SEL_W)) u_rd (
    .clk_i     (rclk_i),
    .rst_ni    (rst_ni),
    .sync_sel_i(sync_sel_i),
    .rd_en_i   (rd_en_i),
    .wgray_i   (wgray),
    .rgray_o   (rgray),
    .raddr_o   (raddr),
    .empty_o   (rd_stall_o)
  );

  always_ff @(posedge wclk_i) begin
    if (wr_take) mem_q[waddr] <= wr_data_i;
  end

  // head word is read combinationally: no pop needed to see it
  assign rd_data_o = mem_q[raddr];

  p_head_hold_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_stall_o && !rd_en_i) |=> $stable(rd_data_o));
endmodule

// File: tb/dcf_fifo_tb_top.sv
`timescale 1ns/1ps
module dcf_fifo_tb_top;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [0:0]    sync_sel = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_stall, rd_stall;
  logic [DW-1:0] rd_data;

  bit  w_run = 1'b1, r_run = 1'b1;
  real w_half = 2.0, r_half = 2.0;
  int  n_chk = 0, n_fail = 0;
  int  seq = 0;
  int  w_full_seen = 0, r_empty_seen = 0;

  dcf_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .wclk_i    (wclk),
    .rclk_i    (rclk),
    .rst_ni    (rst_ni),
    .sync_sel_i(sync_sel),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .wr_stall_o(wr_stall),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .rd_stall_o(rd_stall)
  );

  initial forever begin #(w_half); if (w_run) wclk = ~wclk; end
  initial begin #0.7; forever begin #(r_half); if (r_run) rclk = ~rclk; end end

  function automatic logic [DW-1:0] pat(int k);
    return DW'(k * 40503 + 4660);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stream(int n, int wgap, int rgap, bit halt_en, string tag);
    int base = seq;
    w_full_seen = 0; r_empty_seen = 0;
    fork
      begin : writer
        int i = 0, cyc = 0;
        while (i < n) begin
          @(negedge wclk); cyc++;
          if (wgap == 0 || cyc % wgap != 0) begin
            wr_en = 1'b1;
            if (!wr_stall) begin wr_data = pat(base + i); i++; end
            else begin wr_data = ~pat(base + i); w_full_seen++; end
          end else wr_en = 1'b0;
        end
        @(negedge wclk); wr_en = 1'b0;
      end
      begin : reader
        int j = 0, cyc = 0;
        bit got = 0;
        while (j < n) begin
          @(negedge rclk); cyc++;
          if (rgap == 0 || cyc % rgap != 0) begin
            rd_en = 1'b1;
            if (!rd_stall) begin
              chk(rd_data == pat(base + j), tag, int'(rd_data), int'(pat(base + j)));
              j++; got = 1;
            end else if (got) r_empty_seen++;
          end else rd_en = 1'b0;
        end
        @(negedge rclk); rd_en = 1'b0;
      end
      begin : halter
        if (halt_en) begin
          repeat (5) begin
            #37; w_run = 0; #53; w_run = 1;
            #29; r_run = 0; #61; r_run = 1;
          end
        end
      end
    join
    seq += n;
  endtask

  task automatic measure_lat(output int lat);
    @(negedge wclk); wr_en = 1'b1; wr_data = pat(seq);
    @(negedge wclk); wr_en = 1'b0;
    lat = 0;
    while (rd_stall) begin @(negedge rclk); lat++; end
    chk(rd_data == pat(seq), "R6 data", int'(rd_data), int'(pat(seq)));
    rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    seq++;
    repeat (10) @(negedge wclk);
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat0, lat1, cnt, run;
    #20.3 rst_ni = 1'b1;
    repeat (3) @(negedge rclk);
    // R1: reset state
    chk(rd_stall == 1'b1, "R1 rd_stall", int'(rd_stall), 1);
    chk(wr_stall == 1'b0, "R1 wr_stall", int'(wr_stall), 0);

    // R5: pops on an empty FIFO are ignored
    repeat (10) begin @(negedge rclk); rd_en = 1'b1; end
    @(negedge rclk); rd_en = 1'b0;
    chk(rd_stall == 1'b1, "R5 still empty", int'(rd_stall), 1);

    // R6: latency step between synchronizer settings (equal clocks)
    sync_sel = 1'b0; repeat (5) @(negedge wclk);
    measure_lat(lat0);
    sync_sel = 1'b1; repeat (5) @(negedge wclk);
    measure_lat(lat1);
    chk(lat1 - lat0 == 1, "R6 latency step", lat1 - lat0, 1);
    chk(rd_stall == 1'b1, "R5 empty after single pop", int'(rd_stall), 1);

    // R7: full rate with matched clocks, both settings
    for (int s = 0; s < 2; s++) begin
      sync_sel = s[0]; repeat (5) @(negedge wclk);
      stream(200, 0, 0, 0, "R7 data");
      chk(w_full_seen == 0, "R7 write stalls", w_full_seen, 0);
      chk(r_empty_seen == 0, "R7 read stalls", r_empty_seen, 0);
    end

    // R2/R3: sweep clock ratios, enable patterns, synchronizer depth
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 5; c++) begin
        case (c)
          0: begin w_half = 2.0; r_half = 2.0; end
          1: begin w_half = 2.0; r_half = 3.5; end
          2: begin w_half = 3.5; r_half = 2.0; end
          3: begin w_half = 2.0; r_half = 7.0; end
          default: begin w_half = 7.0; r_half = 2.0; end
        endcase
        sync_sel = s[0];
        repeat (6) @(negedge rclk);
        stream(60, (c == 0) ? 0 : c + 1, (c % 2 == 1) ? 0 : 3, 0,
               (c == 0) ? "R2 order" : "R3 ratio");
      end
    end

    // R8: clocks halted repeatedly mid-stream
    w_half = 2.0; r_half = 3.5;
    stream(120, 0, 0, 1, "R8 halting");
    w_half = 2.0; r_half = 2.0;
    repeat (6) @(negedge rclk);

    // R4: reader clock stopped, fill until stalled
    r_run = 0;
    cnt = 0; run = 0;
    while (run < 12) begin
      @(negedge wclk); wr_en = 1'b1;
      if (!wr_stall) begin wr_data = pat(seq + cnt); cnt++; run = 0; end
      else begin wr_data = 16'hDEAD; run++; end
    end
    @(negedge wclk); wr_en = 1'b0;
    chk(cnt == DEPTH, "R4 fill count", cnt, DEPTH);
    chk(wr_stall == 1'b1, "R4 stall held", int'(wr_stall), 1);
    // R8: write clock stopped while reader resumes
    w_run = 0; r_run = 1;
    repeat (10) @(negedge rclk);
    chk(rd_data == pat(seq), "R9 head visible", int'(rd_data), int'(pat(seq)));
    @(negedge rclk);
    chk(rd_data == pat(seq), "R9 head held", int'(rd_data), int'(pat(seq)));
    cnt = 0;
    while (cnt < DEPTH) begin
      @(negedge rclk);
      if (!rd_stall) begin
        chk(rd_data == pat(seq + cnt), "R8 drain", int'(rd_data), int'(pat(seq + cnt)));
        rd_en = 1'b1; cnt++;
      end else rd_en = 1'b0;
    end
    @(negedge rclk); rd_en = 1'b0;
    repeat (20) @(negedge rclk);
    chk(rd_stall == 1'b1, "R4 refused writes absent", int'(rd_stall), 1);
    seq += DEPTH;
    w_run = 1;
    repeat (20) @(negedge wclk);
    chk(wr_stall == 1'b0, "R4 stall released", int'(wr_stall), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule